// File: doc/BRIEF.md
# Serial Frame Shifter with Parity

This block moves one serial frame at a time for an SPI-style port. It takes a parallel word from a transmit queue and sends it out one bit per shift strobe. At the same time it gathers incoming bits on sample strobes and hands the finished word to a receive queue. The frame length can be set from 8 to 32 bits. Bits can go out most significant first or least significant first. An even or odd parity bit can be added as the last bit of the frame, and a parity check runs on the received frame.

Clock generation, chip select and the queues themselves live outside. The surrounding logic produces `shift_stb` and `sample_stb` from its serial clock and keeps the frame settings steady. A frame starts when the block is idle and the transmit queue offers a word. The block pops that word and takes a copy of the settings. The frame ends on the sample strobe that captures the last bit. The block then pushes the received word and drops back to idle.

Top module: `frame_shifter`

## Requirements
- R1: When idle with `tx_avail` high, `tx_pop` is high in that same cycle. The word is loaded and `busy` is high from the next cycle until the frame completes.
- R2: The effective frame length N is `cfg_len` clamped to the range 8..32. A value below 8 acts as 8 and a value above 32 acts as 32.
- R3: With `cfg_lsb_first`=0, `txd` first shows the highest data bit. Each shift strobe moves it one bit toward bit 0. `txd` is 0 when idle and after every frame bit has been shifted out.
- R4: With `cfg_lsb_first`=1, the data bits leave in the order bit 0, bit 1, and so on up to the highest data bit.
- R5: With `cfg_par_en`=1, the frame carries N-1 data bits and then one parity bit, sent last. The parity bit is computed over the data bits when the word is loaded. With `cfg_par_odd`=0 it makes the count of ones across the whole frame even; with 1, odd.
- R6: On receive, the first sampled bit becomes the highest data bit when MSB-first and bit 0 when LSB-first. `rx_data` holds the N (or N-1) data bits, zero-extended, and keeps its value until the next push.
- R7: `rx_push` and `frame_done` are high for exactly one cycle, in the cycle after the sample strobe that captures bit N. `busy` falls in that same cycle.
- R8: `par_err` goes high at a push when parity is enabled and the count of ones in the received frame does not match the selected sense. It stays high until a `par_err_clr` pulse. If a new error and a clear happen in the same cycle, the flag ends up set.
- R9: Shift and sample strobes that arrive while the block is idle have no effect.
- R10: The length, order and parity settings are copied when a frame starts. Changing the settings inputs during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 6 | Requested frame length in bits |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_par_en | input | 1 | 1 = add a parity bit at the end of the frame |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| tx_avail | input | 1 | Transmit queue has a word |
| tx_data | input | 32 | Word at the head of the transmit queue |
| tx_pop | output | 1 | Word accepted from the transmit queue this cycle |
| shift_stb | input | 1 | Move to the next transmit bit |
| sample_stb | input | 1 | Capture `rxd` |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| rx_push | output | 1 | Received word is valid this cycle |
| rx_data | output | 32 | Received data word |
| frame_done | output | 1 | Frame completed (one-cycle pulse) |
| par_err_clr | input | 1 | Clears the parity error flag |
| par_err | output | 1 | Sticky parity error flag |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest case to reach from the ports is a parity error that lands in the same cycle as a clear. It needs a parity frame whose receive line has been corrupted on purpose, with `par_err_clr` held high across its final sample strobe. The bench produces it by looping `txd` back to `rxd` and flipping a single bit. Changing the settings in the middle of a frame, and lengths outside the legal range, are driven in their own directed frames. Randomised frames then cover every combination of order, parity and length. A behavioural queue model is compared against every output on every cycle.

// File: rtl/fsh_pkg.sv
// Shared constants, the frame settings type and bit helpers for the frame shifter.
// Assumes the maximum frame width fits the length field LEN_W.
package fsh_pkg;
    localparam int MAX_W   = 32;
    localparam int MIN_LEN = 8;
    localparam int LEN_W   = $clog2(MAX_W + 1);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             lsb_first;
        logic             par_en;
        logic             par_odd;
    } fcfg_t;

    // Limit a requested length to the legal range MIN_LEN..MAX_W.
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] n);
        if (n < LEN_W'(MIN_LEN))     return LEN_W'(MIN_LEN);
        else if (n > LEN_W'(MAX_W))  return LEN_W'(MAX_W);
        else                         return n;
    endfunction

    // Mask with the n lowest bits set.
    function automatic logic [MAX_W-1:0] low_mask(input logic [LEN_W-1:0] n);
        logic [MAX_W-1:0] m;
        for (int i = 0; i < MAX_W; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    // Mirror a word end for end.
    function automatic logic [MAX_W-1:0] bit_rev(input logic [MAX_W-1:0] x);
        logic [MAX_W-1:0] r;
        for (int i = 0; i < MAX_W; i++) r[i] = x[MAX_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/fsh_tx_path.sv
// Transmit side: lays out the popped word as a frame (order, parity) and
// shifts it out toward the top frame bit on each accepted shift strobe.
// Assumes load and shift_en never occur in the same cycle (load needs idle).
module fsh_tx_path
    import fsh_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  fcfg_t               cfg_live,
    input  logic [MAX_W-1:0]    tx_data,
    input  logic                shift_en,
    input  logic                active,
    input  logic [LEN_W-1:0]    frame_len,
    output logic                txd
);
    logic [LEN_W-1:0] d_len;
    logic [MAX_W-1:0] d_bits, payload, frame_word, sreg, aligned;
    logic             par_bit;

    // Build the frame word from the live settings at load time (R4, R5).
    always_comb begin
        d_len      = cfg_live.par_en ? cfg_live.len - LEN_W'(1) : cfg_live.len;
        d_bits     = tx_data & low_mask(d_len);
        payload    = cfg_live.lsb_first ? (bit_rev(tx_data) >> (LEN_W'(MAX_W) - d_len)) : d_bits;
        par_bit    = (^d_bits) ^ cfg_live.par_odd;
        frame_word = cfg_live.par_en ? {payload[MAX_W-2:0], par_bit} : payload;
    end

    // Shift register: load a fresh frame or advance one bit per strobe (R3).
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= '0;
        else if (load)     sreg <= frame_word;
        else if (shift_en) sreg <= {sreg[MAX_W-2:0], 1'b0};
    end

    // Present the top bit of the active frame; 0 when idle (R3).
    always_comb begin
        aligned = sreg >> (frame_len - LEN_W'(1));
        txd     = active & aligned[0];
    end

    AST_TXD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !shift_en) |=> (!active || $stable(txd))); // R3
endmodule

// File: rtl/fsh_rx_path.sv
// Receive side: collects sampled bits, and on the last one unloads the data
// word in the latched bit order, checks parity and updates the sticky flag.
// Assumes frame settings stay steady for the frame (latched by the top).
module fsh_rx_path
    import fsh_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                sample_en,
    input  logic                rxd,
    input  fcfg_t               fcfg,
    input  logic                par_err_clr,
    output logic                last,
    output logic                rx_push,
    output logic [MAX_W-1:0]    rx_data,
    output logic                frame_done,
    output logic                par_err
);
    logic [MAX_W-1:0] rx_sreg, captured, f_bits, payload, data_word;
    logic [LEN_W-1:0] cnt, d_len;
    logic             mismatch;

    // Decode the frame as it would stand with the current bit included (R6).
    always_comb begin
        captured  = {rx_sreg[MAX_W-2:0], rxd};
        d_len     = fcfg.par_en ? fcfg.len - LEN_W'(1) : fcfg.len;
        f_bits    = captured & low_mask(fcfg.len);
        payload   = fcfg.par_en ? (f_bits >> 1) : f_bits;
        data_word = fcfg.lsb_first ? (bit_rev(payload) >> (LEN_W'(MAX_W) - d_len)) : payload;
        mismatch  = fcfg.par_en & ((^f_bits) ^ fcfg.par_odd);
        last      = sample_en && (cnt == fcfg.len - LEN_W'(1));
    end

    // Bit capture and counting within the frame (R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sreg <= '0;
            cnt     <= '0;
        end else if (load) begin
            cnt     <= '0;
        end else if (sample_en) begin
            rx_sreg <= captured;
            cnt     <= last ? '0 : cnt + LEN_W'(1);
        end
    end

    // Completion pulses and word hand-off (R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_push    <= 1'b0;
            frame_done <= 1'b0;
            rx_data    <= '0;
        end else begin
            rx_push    <= last;
            frame_done <= last;
            if (last) rx_data <= data_word;
        end
    end

    // Sticky parity error; a new error wins over a clear (R8).
    always_ff @(posedge clk) begin
        if (!rst_n)                 par_err <= 1'b0;
        else if (last && mismatch)  par_err <= 1'b1;
        else if (par_err_clr)       par_err <= 1'b0;
    end

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < fcfg.len); // R7
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !par_err_clr) |=> par_err); // R8
    AST_ERR_AT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> rx_push); // R8
endmodule

// File: rtl/frame_shifter.sv
// Top of the serial frame shifter. Starts a frame when idle and a transmit
// word is offered, latches the settings for that frame, and ends it on the
// sample strobe that captures the last bit. Strobes come from an external
// serial clock generator; strobes while idle are ignored.
module frame_shifter
    import fsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_lsb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              tx_avail,
    input  logic [MAX_W-1:0]  tx_data,
    output logic              tx_pop,
    input  logic              shift_stb,
    input  logic              sample_stb,
    input  logic              rxd,
    output logic              txd,
    output logic              rx_push,
    output logic [MAX_W-1:0]  rx_data,
    output logic              frame_done,
    input  logic              par_err_clr,
    output logic              par_err,
    output logic              busy
);
    fcfg_t cfg_live, cfg_q;
    logic  active, load, last;

    // Gather the live settings with the length clamped (R2).
    always_comb begin
        cfg_live.len       = clamp_len(cfg_len);
        cfg_live.lsb_first = cfg_lsb_first;
        cfg_live.par_en    = cfg_par_en;
        cfg_live.par_odd   = cfg_par_odd;
        load               = tx_avail && !active;
    end

    // Frame state and latched settings (R1, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cfg_q  <= '{len: LEN_W'(MIN_LEN), lsb_first: 1'b0, par_en: 1'b0, par_odd: 1'b0};
        end else if (load) begin
            active <= 1'b1;
            cfg_q  <= cfg_live;
        end else if (last) begin
            active <= 1'b0;
        end
    end

    assign tx_pop = load;
    assign busy   = active;

    fsh_tx_path u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cfg_live  (cfg_live),
        .tx_data   (tx_data),
        .shift_en  (active && shift_stb),
        .active    (active),
        .frame_len (cfg_q.len),
        .txd       (txd)
    );

    fsh_rx_path u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .sample_en   (active && sample_stb),
        .rxd         (rxd),
        .fcfg        (cfg_q),
        .par_err_clr (par_err_clr),
        .last        (last),
        .rx_push     (rx_push),
        .rx_data     (rx_data),
        .frame_done  (frame_done),
        .par_err     (par_err)
    );

    AST_DONE_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy); // R7
    AST_BUSY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> busy); // R1
    AST_PUSH_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(sample_stb)); // R7
endmodule

// File: tb/frame_shifter_tb.sv
// Bench: behavioural queue model updated on each rising edge, and a full
// comparison of the outputs at each falling edge plus 2 ns.
module frame_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_len = 6'd8;
    logic        cfg_lsb_first = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic        tx_avail = 1'b0;
    logic [31:0] tx_data = '0;
    logic        shift_stb = 1'b0, sample_stb = 1'b0, rxd = 1'b0, par_err_clr = 1'b0;
    logic        tx_pop, txd, rx_push, frame_done, par_err, busy;
    logic [31:0] rx_data;

    int checks = 0, failures = 0;
    string g_tag = "";

    always #4 clk = ~clk;

    frame_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .tx_avail(tx_avail),
        .tx_data(tx_data), .tx_pop(tx_pop), .shift_stb(shift_stb), .sample_stb(sample_stb),
        .rxd(rxd), .txd(txd), .rx_push(rx_push), .rx_data(rx_data), .frame_done(frame_done),
        .par_err_clr(par_err_clr), .par_err(par_err), .busy(busy)
    );

    // ---------------- reference model ----------------
    bit          m_txq[$];
    bit          m_rxq[$];
    bit          m_active, m_push, m_done, m_err, m_lsb, m_par, m_odd;
    logic [31:0] m_word;
    int          m_len;

    function automatic int clampn(int n);
        return (n < 8) ? 8 : (n > 32) ? 32 : n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txq.delete(); m_rxq.delete();
            m_active = 0; m_push = 0; m_done = 0; m_err = 0; m_word = '0; m_len = 8;
        end else begin
            m_push = 0; m_done = 0;
            if (par_err_clr) m_err = 0;
            if (!m_active && tx_avail) begin
                int  d;
                bit  x;
                m_len = clampn(int'(cfg_len));
                m_lsb = cfg_lsb_first; m_par = cfg_par_en; m_odd = cfg_par_odd;
                d = m_par ? m_len - 1 : m_len;
                x = 0;
                m_txq.delete(); m_rxq.delete();
                for (int i = 0; i < d; i++) x ^= tx_data[i];
                if (!m_lsb) for (int i = d - 1; i >= 0; i--) m_txq.push_back(tx_data[i]);
                else        for (int i = 0; i < d; i++)      m_txq.push_back(tx_data[i]);
                if (m_par) m_txq.push_back(x ^ m_odd);
                m_active = 1;
            end else if (m_active) begin
                if (shift_stb && m_txq.size() > 0) void'(m_txq.pop_front());
                if (sample_stb) begin
                    m_rxq.push_back(rxd);
                    if (m_rxq.size() == m_len) begin
                        int d;
                        bit x;
                        d = m_par ? m_len - 1 : m_len;
                        m_word = '0; x = 0;
                        for (int i = 0; i < d; i++) begin
                            if (m_lsb) m_word[i] = m_rxq[i];
                            else       m_word[d-1-i] = m_rxq[i];
                        end
                        for (int i = 0; i < m_len; i++) x ^= m_rxq[i];
                        if (m_par && (x != m_odd)) m_err = 1;
                        m_push = 1; m_done = 1; m_active = 0;
                    end
                end
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic string pick(string dflt);
        return (g_tag != "") ? g_tag : dflt;
    endfunction

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            bit etx;
            etx = (m_active && m_txq.size() > 0) ? m_txq[0] : 1'b0;
            chk(pick("R1 busy"), 32'(busy), 32'(m_active));
            chk(pick("R1 tx_pop"), 32'(tx_pop), 32'(!m_active && tx_avail));
            chk(pick(m_par && m_txq.size() == 1 ? "R5 txd" : (m_lsb ? "R4 txd" : "R3 txd")),
                32'(txd), 32'(etx));
            chk(pick("R7 rx_push"), 32'(rx_push), 32'(m_push));
            chk(pick("R7 frame_done"), 32'(frame_done), 32'(m_done));
            chk(pick("R6 rx_data"), rx_data, m_word);
            chk(pick("R8 par_err"), 32'(par_err), 32'(m_err));
        end
    end

    // ---------------- stimulus ----------------
    // mode: 0 random rxd, 1 loopback, 2 loopback with first bit flipped
    task automatic run_frame(int len, bit lsb, bit par, bit odd, logic [31:0] data,
                             int mode, int gap, bit scramble);
        int n;
        n = clampn(len);
        @(negedge clk);
        cfg_len = 6'(len); cfg_lsb_first = lsb; cfg_par_en = par; cfg_par_odd = odd;
        tx_data = data; tx_avail = 1'b1;
        @(negedge clk);
        tx_avail = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (scramble && k == 2) begin   // R10: settings change mid-frame
                cfg_len = 6'(int'(cfg_len) ^ 5); cfg_lsb_first = ~lsb;
                cfg_par_en = ~par; cfg_par_odd = ~odd;
            end
            rxd = (mode == 0) ? 1'($urandom) : (txd ^ (mode == 2 && k == 0));
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
            repeat (gap) @(negedge clk);
            shift_stb = 1'b1;
            @(negedge clk);
            shift_stb = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // Reset state (R1, R3, R7, R8)
        chk("R1 reset busy", 32'(busy), 0);
        chk("R3 reset txd", 32'(txd), 0);
        chk("R7 reset rx_push", 32'(rx_push), 0);
        chk("R8 reset par_err", 32'(par_err), 0);

        // R3 / R6: MSB-first loopback, several lengths
        run_frame(8, 0, 0, 0, 32'h0000_00A5, 1, 0, 0);
        run_frame(16, 0, 0, 0, 32'h0000_C3F1, 1, 1, 0);
        run_frame(32, 0, 0, 0, 32'hDEAD_BEEF, 1, 0, 0);
        // R4: LSB-first
        run_frame(12, 1, 0, 0, 32'h0000_0B3D, 1, 0, 0);
        run_frame(32, 1, 0, 0, 32'h8000_0001, 1, 2, 0);
        // R5: parity even and odd, both orders
        run_frame(9, 0, 1, 0, 32'h0000_00FF, 1, 0, 0);
        run_frame(32, 0, 1, 1, 32'h7FFF_FFFF, 1, 0, 0);
        run_frame(17, 1, 1, 1, 32'h0000_1234, 1, 1, 0);

        // R2: clamped lengths
        g_tag = "R2";
        run_frame(3, 0, 0, 0, 32'h0000_005A, 1, 0, 0);
        run_frame(45, 1, 1, 0, 32'h1357_9BDF, 1, 0, 0);

        // R9: strobes while idle
        g_tag = "R9";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rxd = 1'(i); sample_stb = 1'b1; shift_stb = i[0];
        end
        @(negedge clk);
        sample_stb = 1'b0; shift_stb = 1'b0;
        repeat (2) @(negedge clk);
        run_frame(8, 0, 0, 0, 32'h0000_0081, 1, 0, 0);

        // R10: settings scrambled mid-frame
        g_tag = "R10";
        run_frame(20, 0, 1, 0, 32'h000A_5A5A, 1, 0, 1);
        run_frame(11, 1, 0, 1, 32'h0000_0777, 1, 1, 1);

        // R8: error sets, sticks, clears; set beats clear
        g_tag = "R8";
        run_frame(10, 0, 1, 0, 32'h0000_0155, 2, 0, 0);
        run_frame(10, 0, 1, 0, 32'h0000_0155, 1, 0, 0);
        @(negedge clk); par_err_clr = 1'b1;
        @(negedge clk); par_err_clr = 1'b0;
        @(negedge clk); par_err_clr = 1'b1;
        run_frame(14, 1, 1, 1, 32'h0000_2AAA, 2, 0, 0);
        par_err_clr = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk); par_err_clr = 1'b1;
        @(negedge clk); par_err_clr = 1'b0;

        // Random frames across all settings (R3..R8)
        g_tag = "";
        for (int f = 0; f < 80; f++) begin
            run_frame(int'($urandom_range(0, 40)), 1'($urandom), 1'($urandom), 1'($urandom),
                      $urandom, int'($urandom_range(0, 2)), int'($urandom_range(0, 2)), 0);
            if (f % 9 == 0) begin
                @(negedge clk); par_err_clr = 1'b1;
                @(negedge clk); par_err_clr = 1'b0;
            end
        end

        repeat (4) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule